// File: doc/BRIEF.md
# Jump and Call Target Generator

This unit sits in the decode stage of a core whose instruction stream mixes 24-bit and 16-bit encodings. It receives three instruction bytes (byte 0 in the lowest bits) together with the current program counter and the value of the source register named by the instruction. On each valid strobe it registers the instruction length, the sequential next PC, and a redirect flag with its target address. It also registers a return-address write for register a0 and the address and destination register of a PC-relative literal load.

It covers the direct call, the register-indirect call, the direct jump, the register jump, the return and the PC-relative literal load. Windowed call and return encodings depend on an option input. When the option is off they raise an illegal flag. When it is on they are accepted without a redirect, because the windowed logic handles them elsewhere. Reserved encodings inside the covered groups raise the illegal flag. Fetch, memory access and the register file are outside the unit. The caller supplies `srcVal`, the value of the register indexed by `instBytes[11:8]`, in the same cycle as the strobe.

Top module: `xfer_target_unit`

## Requirements
- R1: The length is 2 bytes when `instBytes[3:0]` is 8 or more and 3 bytes otherwise. `nextPc` is the PC plus that length.
- R2: Direct call (`instBytes[3:0]`=5, `instBytes[5:4]`=0) redirects to `{pc[31:2],2'b00}` + 4 + (sign-extended 18-bit offset << 2). The offset is `{instBytes[23:8], instBytes[7:6]}`. The call also writes `nextPc` to a0 (`raWrEn`=1, `raData`=`nextPc`).
- R3: Direct jump (`instBytes[3:0]`=6, `instBytes[5:4]`=0) redirects to pc + 4 + sign-extended 18-bit offset. No word shift or alignment is applied, and a0 is not written.
- R4: In the register-jump group (`instBytes[3:0]`=0, `instBytes[23:12]`=0, `instBytes[7:6]`=2), `instBytes[5:4]` of 0 (return) or 2 (jump) redirects to `srcVal` without writing a0.
- R5: Register-indirect call (same group, `instBytes[7:6]`=3, `instBytes[5:4]`=0) redirects to `srcVal` and writes `nextPc` to a0. The target is the source value presented with the strobe, so a source of a0 jumps to the old a0 value.
- R6: Literal load (`instBytes[3:0]`=1) sets `litValid`. `litAddr` = `{14'h3FFF, instBytes[23:8], 2'b00}` + ((pc + 3) with its low 2 bits cleared). `litDest` = `instBytes[7:4]`.
- R7: The windowed encodings are the direct call with `instBytes[5:4]`≠0, the indirect call with `instBytes[5:4]`≠0, and the register-jump group with `instBytes[5:4]`=1. They raise `illegal` exactly when `windowEn` is 0, and they never redirect or write a0.
- R8: Reserved encodings in the register-jump group raise `illegal` without a redirect. These are `instBytes[7:6]` of 0 or 1, and `instBytes[7:6]`=2 with `instBytes[5:4]`=3.
- R9: All outputs are registered: `outValid` follows `inValid` by one cycle. When `outValid` is low, `redirect`, `raWrEn`, `litValid` and `illegal` are low.
- R10: Any other encoding produces only length and next PC. It sets no redirect, no a0 write, no literal load and no illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction present this cycle |
| instBytes | input | 24 | Instruction bytes, byte 0 in bits 7:0 |
| pc | input | 32 | Address of the instruction |
| srcVal | input | 32 | Value of register indexed by instBytes[11:8] |
| windowEn | input | 1 | Windowed-register option enable |
| outValid | output | 1 | Registered result valid |
| instLen | output | 2 | Instruction length in bytes |
| nextPc | output | 32 | Sequential next PC |
| redirect | output | 1 | Control transfer taken |
| target | output | 32 | Redirect address |
| raWrEn | output | 1 | Write return address to a0 |
| raData | output | 32 | Return address value |
| litValid | output | 1 | Literal load requested |
| litAddr | output | 32 | Literal load address |
| litDest | output | 4 | Literal load destination register |
| illegal | output | 1 | Illegal or disabled encoding |

## Verification
The hardest case to reach is the indirect call whose source register is a0. In that case the target must be the old a0 while the same result also carries a new a0. Random bytes almost never hit it, so the bench drives it directly with distinct `srcVal` and PC values. The register-jump group needs twelve specific zero bits, so the random generator forces them for a share of its stimulus. Windowed encodings are then swept with the option both on and off.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_CALL, TGT_JUMP, TGT_REG} tgtSel_e;

  typedef struct packed {
    logic    redirect;
    tgtSel_e tgtSel;
    logic    raWr;
    logic    litLoad;
    logic    illegal;
  } xferStrobe_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic [23:0]  instBytes,
  input  logic         windowEn,
  output xferStrobe_t  strobe
);
  logic [3:0] op0, op1, op2, rFld;
  logic [1:0] nFld, mFld;
  logic       inJrGroup;

  assign op0  = instBytes[3:0];
  assign nFld = instBytes[5:4];
  assign mFld = instBytes[7:6];
  assign rFld = instBytes[15:12];
  assign op1  = instBytes[19:16];
  assign op2  = instBytes[23:20];
  assign inJrGroup = (op0 == 4'd0) && (op1 == 4'd0) && (op2 == 4'd0) && (rFld == 4'd0);

  always_comb begin
    strobe = '0;
    strobe.tgtSel = TGT_NONE;
    if (inJrGroup) begin
      case (mFld)
        2'd2: begin
          if (nFld == 2'd0 || nFld == 2'd2) begin
            strobe.redirect = 1'b1;
            strobe.tgtSel   = TGT_REG;
          end else if (nFld == 2'd1) begin
            strobe.illegal = !windowEn;
          end else begin
            strobe.illegal = 1'b1;
          end
        end
        2'd3: begin
          if (nFld == 2'd0) begin
            strobe.redirect = 1'b1;
            strobe.tgtSel   = TGT_REG;
            strobe.raWr     = 1'b1;
          end else begin
            strobe.illegal = !windowEn;
          end
        end
        default: strobe.illegal = 1'b1;
      endcase
    end else begin
      case (op0)
        4'd1: strobe.litLoad = 1'b1;
        4'd5: begin
          if (nFld == 2'd0) begin
            strobe.redirect = 1'b1;
            strobe.tgtSel   = TGT_CALL;
            strobe.raWr     = 1'b1;
          end else begin
            strobe.illegal = !windowEn;
          end
        end
        4'd6: begin
          if (nFld == 2'd0) begin
            strobe.redirect = 1'b1;
            strobe.tgtSel   = TGT_JUMP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 18,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [23:0]       instBytes,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] srcVal,
  input  xferStrobe_t       strobe,
  output logic              outValid,
  output logic [1:0]        instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic              redirect,
  output logic [ADDR_W-1:0] target,
  output logic              raWrEn,
  output logic [ADDR_W-1:0] raData,
  output logic              litValid,
  output logic [ADDR_W-1:0] litAddr,
  output logic [3:0]        litDest,
  output logic              illegal
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam int LIT_ONES = ADDR_W - IMM_W - 2;

  logic [1:0]        lenC;
  logic [ADDR_W-1:0] seqPc, offSext, callTgt, jumpTgt, tgtC, litBase, litC, pcWord;
  logic [OFF_W-1:0]  offRaw;
  logic [IMM_W-1:0]  imm16;

  assign lenC    = (instBytes[3]) ? 2'd2 : 2'd3;
  assign seqPc   = pc + ADDR_W'(lenC);
  assign offRaw  = {instBytes[23:8], instBytes[7:6]};
  assign offSext = {{EXT_W{offRaw[OFF_W-1]}}, offRaw};
  assign pcWord  = {pc[ADDR_W-1:2], 2'b00};
  assign callTgt = pcWord + (offSext << 2) + ADDR_W'(4);
  assign jumpTgt = pc + ADDR_W'(4) + offSext;
  assign imm16   = instBytes[23:8];
  assign litBase = {{LIT_ONES{1'b1}}, imm16, 2'b00};
  assign litC    = litBase + ((pc + ADDR_W'(3)) & ~ADDR_W'(3));

  always_comb begin
    case (strobe.tgtSel)
      TGT_CALL: tgtC = callTgt;
      TGT_JUMP: tgtC = jumpTgt;
      TGT_REG:  tgtC = srcVal;
      default:  tgtC = seqPc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      instLen  <= 2'd0;
      nextPc   <= '0;
      redirect <= 1'b0;
      target   <= '0;
      raWrEn   <= 1'b0;
      raData   <= '0;
      litValid <= 1'b0;
      litAddr  <= '0;
      litDest  <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      redirect <= inValid && strobe.redirect;
      raWrEn   <= inValid && strobe.raWr;
      litValid <= inValid && strobe.litLoad;
      illegal  <= inValid && strobe.illegal;
      if (inValid) begin
        instLen <= lenC;
        nextPc  <= seqPc;
        target  <= tgtC;
        raData  <= seqPc;
        litAddr <= litC;
        litDest <= instBytes[7:4];
      end
    end
  end
endmodule

// File: rtl/xfer_target_unit.sv
module xfer_target_unit
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [23:0]       instBytes,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] srcVal,
  input  logic              windowEn,
  output logic              outValid,
  output logic [1:0]        instLen,
  output logic [ADDR_W-1:0] nextPc,
  output logic              redirect,
  output logic [ADDR_W-1:0] target,
  output logic              raWrEn,
  output logic [ADDR_W-1:0] raData,
  output logic              litValid,
  output logic [ADDR_W-1:0] litAddr,
  output logic [3:0]        litDest,
  output logic              illegal
);
  xferStrobe_t strobe;

  xfer_ctrl u_ctrl (
    .instBytes(instBytes),
    .windowEn (windowEn),
    .strobe   (strobe)
  );

  xfer_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .instBytes(instBytes),
    .pc       (pc),
    .srcVal   (srcVal),
    .strobe   (strobe),
    .outValid (outValid),
    .instLen  (instLen),
    .nextPc   (nextPc),
    .redirect (redirect),
    .target   (target),
    .raWrEn   (raWrEn),
    .raData   (raData),
    .litValid (litValid),
    .litAddr  (litAddr),
    .litDest  (litDest),
    .illegal  (illegal)
  );
endmodule

// File: rtl/xfer_target_checker.sv
module xfer_target_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [23:0]       instBytes,
  input logic [ADDR_W-1:0] pc,
  input logic              windowEn,
  input logic              outValid,
  input logic [1:0]        instLen,
  input logic [ADDR_W-1:0] nextPc,
  input logic              redirect,
  input logic              raWrEn,
  input logic [ADDR_W-1:0] raData,
  input logic              litValid,
  input logic              illegal
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> !(redirect || raWrEn || litValid || illegal));

  assert_len_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (instLen == 2'd2 || instLen == 2'd3));

  assert_next_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> nextPc == $past(pc) + ADDR_W'(instLen));

  assert_ra_is_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    raWrEn |-> (raData == nextPc && redirect));

  assert_illegal_no_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!redirect && !raWrEn && !litValid));

  assert_windowed_call_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && instBytes[3:0] == 4'd5 && instBytes[5:4] != 2'd0)
      |=> (illegal == !$past(windowEn) && !redirect));
endmodule

bind xfer_target_unit xfer_target_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .instBytes(instBytes), .pc(pc),
  .windowEn(windowEn), .outValid(outValid), .instLen(instLen), .nextPc(nextPc),
  .redirect(redirect), .raWrEn(raWrEn), .raData(raData), .litValid(litValid),
  .illegal(illegal)
);

// File: tb/tb_xfer_target_unit.sv
module tb_xfer_target_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] instBytes = '0;
  logic [31:0] pc = '0;
  logic [31:0] srcVal = '0;
  logic        windowEn = 1'b0;
  logic        outValid, redirect, raWrEn, litValid, illegal;
  logic [1:0]  instLen;
  logic [31:0] nextPc, target, raData, litAddr;
  logic [3:0]  litDest;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_target_unit dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .instBytes(instBytes), .pc(pc),
    .srcVal(srcVal), .windowEn(windowEn), .outValid(outValid), .instLen(instLen),
    .nextPc(nextPc), .redirect(redirect), .target(target), .raWrEn(raWrEn),
    .raData(raData), .litValid(litValid), .litAddr(litAddr), .litDest(litDest),
    .illegal(illegal)
  );

  typedef struct packed {
    logic [1:0]  len;
    logic [31:0] npc;
    logic        redir;
    logic [31:0] tgt;
    logic        ra;
    logic        lit;
    logic [31:0] laddr;
    logic [3:0]  ldest;
    logic        ill;
  } expect_t;

  function automatic expect_t model(input logic [23:0] b, input logic [31:0] p,
                                    input logic [31:0] s, input logic we);
    expect_t e;
    logic [31:0] off;
    logic jr;
    e = '0;
    e.len = (b[3:0] >= 4'd8) ? 2'd2 : 2'd3;
    e.npc = p + {30'd0, e.len};
    off = {{14{b[23]}}, b[23:8], b[7:6]};
    jr = (b[3:0] == 0) && (b[23:12] == 0);
    e.ldest = b[7:4];
    e.laddr = 32'hFFFC0000 + {14'd0, b[23:8], 2'b00} + ((p + 32'd3) & 32'hFFFFFFFC);
    if (jr) begin
      if (b[7:6] == 2) begin
        if (b[5:4] == 0 || b[5:4] == 2) begin e.redir = 1; e.tgt = s; end
        else if (b[5:4] == 1) e.ill = !we;
        else e.ill = 1;
      end else if (b[7:6] == 3) begin
        if (b[5:4] == 0) begin e.redir = 1; e.tgt = s; e.ra = 1; end
        else e.ill = !we;
      end else e.ill = 1;
    end else if (b[3:0] == 1) e.lit = 1;
    else if (b[3:0] == 5) begin
      if (b[5:4] == 0) begin
        e.redir = 1; e.ra = 1;
        e.tgt = (p & 32'hFFFFFFFC) + (off << 2) + 32'd4;
      end else e.ill = !we;
    end else if (b[3:0] == 6 && b[5:4] == 0) begin
      e.redir = 1; e.tgt = p + 32'd4 + off;
    end
    return e;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tagFor(input logic [23:0] b);
    if (b[3:0] == 1) return "R6";
    if (b[3:0] == 5) return (b[5:4] == 0) ? "R2" : "R7";
    if (b[3:0] == 6) return (b[5:4] == 0) ? "R3" : "R10";
    if (b[3:0] == 0 && b[23:12] == 0) begin
      if (b[7:6] == 3) return (b[5:4] == 0) ? "R5" : "R7";
      if (b[7:6] == 2) return (b[5:4] == 1) ? "R7" : ((b[5:4] == 3) ? "R8" : "R4");
      return "R8";
    end
    return "R10";
  endfunction

  task automatic run(input logic [23:0] b, input logic [31:0] p, input logic [31:0] s,
                     input logic we);
    expect_t e;
    string t;
    e = model(b, p, s, we);
    t = tagFor(b);
    @(negedge clk);
    inValid = 1; instBytes = b; pc = p; srcVal = s; windowEn = we;
    @(negedge clk);
    inValid = 0;
    check("R9", "outValid", {31'd0, outValid}, 32'd1);
    check("R1", "instLen", {30'd0, instLen}, {30'd0, e.len});
    check("R1", "nextPc", nextPc, e.npc);
    check(t, "redirect", {31'd0, redirect}, {31'd0, e.redir});
    if (e.redir) check(t, "target", target, e.tgt);
    check(t, "raWrEn", {31'd0, raWrEn}, {31'd0, e.ra});
    if (e.ra) check(t, "raData", raData, e.npc);
    check(t, "litValid", {31'd0, litValid}, {31'd0, e.lit});
    if (e.lit) begin
      check("R6", "litAddr", litAddr, e.laddr);
      check("R6", "litDest", {28'd0, litDest}, {28'd0, e.ldest});
    end
    check(t, "illegal", {31'd0, illegal}, {31'd0, e.ill});
    @(negedge clk);
    check("R9", "idle outputs", {28'd0, outValid, redirect, raWrEn, illegal}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R9", "reset outValid", {31'd0, outValid}, 32'd0);
    check("R9", "reset flags", {29'd0, redirect, raWrEn, illegal}, 32'd0);
    rst_n = 1;

    // R5: indirect call through a0 keeps the old a0 as target
    run(24'h0000C0, 32'h0000_1001, 32'hCAFE_0010, 0);
    run(24'h0005C0, 32'h0000_2002, 32'h1234_5678, 0);
    // R4: return and register jump
    run(24'h000080, 32'h0000_3000, 32'h8000_0004, 0);
    run(24'h0003A0, 32'h0000_3003, 32'h0000_0040, 0);
    // R2: direct call, unaligned pc, positive and negative offsets
    run(24'h000145, 32'h0000_4003, 0, 0);
    run(24'hFFFFC5, 32'h0000_4001, 0, 0);
    // R3: jump, negative offset with no word shift
    run(24'hFFFFC6, 32'h0000_5002, 0, 0);
    run(24'h7FFF46, 32'h0000_5000, 0, 0);
    // R6: literal load with pc low bits set
    run(24'h001231, 32'h0000_6001, 0, 0);
    run(24'hFFFF71, 32'h0000_6003, 0, 0);
    // R7: windowed forms with option off and on
    for (int w = 0; w < 2; w++) begin
      run(24'h000015, 32'h100, 0, w[0]);
      run(24'h0000F0, 32'h104, 0, w[0]);
      run(24'h000090, 32'h108, 32'h55, w[0]);
    end
    // R8: reserved forms
    run(24'h000000, 32'h200, 32'h1, 1);
    run(24'h000040, 32'h204, 32'h1, 1);
    run(24'h0000B0, 32'h208, 32'h1, 1);
    // R10 / R1: narrow and unrelated encodings
    run(24'h00001A, 32'h300, 0, 0);
    run(24'h000216, 32'h304, 0, 0);

    for (int i = 0; i < 400; i++) begin
      b = $urandom();
      case ($urandom_range(0, 4))
        0: b[3:0] = 4'd0;
        1: b[3:0] = 4'd5;
        2: b[3:0] = 4'd6;
        3: b[3:0] = 4'd1;
        default: ;
      endcase
      if (b[3:0] == 0 && $urandom_range(0, 3) != 0) b[23:12] = 12'd0;
      run(b, $urandom(), $urandom(), $urandom_range(0, 1) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule